// File: doc/BRIEF.md
# Turn-Based Source Path Router

This block makes the forwarding decision for one source-routed frame at a six-port switch node. The frame's route is a 24-bit path word: a 3-bit remaining-turn count and seven 3-bit turn fields. Each turn is a relative offset, the number of port positions from the port the frame arrived on to the port it should leave by. The router picks the turn selected by the remaining count and computes the egress port. It then either forwards the path word with the count reduced by one, or reports a typed path event back toward the ingress port the frame came from.

A link-up vector gives the state of each port. A second vector marks which ports face an end node, so that the last hop can be checked for a proper termination. Each presented request produces exactly one registered result one clock later, either a forward or an event. Requests can be presented back to back.

Top module: `spath_router`

## Requirements
- R1: The remaining-turn count sits in path bits [23:21]. Turn i (i = 1..7) sits in bits [3i-1:3i-3]. The turn used at this hop is turn number "count".
- R2: When no event applies, outValid pulses in the cycle after inValid, with outPort = (inPort + turn) mod 6. outPath carries count-1 in bits [23:21] and leaves bits [20:0] unchanged.
- R3: A count of 0 on arrival gives an event with code 2'b11 (unterminated path) and no forward.
- R4: A turn of 0, a turn of 6 or more, or an inPort of 6 or more gives an event with code 2'b10 (nonexistent port).
- R5: If the computed egress port has its portUp bit low, the result is an event with code 2'b01 (down port).
- R6: On the last hop (count 1), if the egress port's edgeMask bit is low, the result is an event with code 2'b11. If the bit is high, the frame is forwarded with count 0.
- R7: When several conditions hold, the priority is R3 first, then R4, then R5, then R6.
- R8: Every event pulses evtValid in the cycle after inValid, with evtPort equal to the ingress port of the failing frame.
- R9: After reset all outputs are zero. Each accepted request yields exactly one of outValid or evtValid, and cycles with inValid low yield neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Routing request present this cycle |
| inPath | input | 24 | Path word: turn count and seven turns |
| inPort | input | 3 | Port index the frame arrived on |
| portUp | input | 6 | Link-up state per port |
| edgeMask | input | 6 | Per port, high when the neighbour is an end node |
| outValid | output | 1 | Forward result valid |
| outPort | output | 3 | Egress port of the forwarded frame |
| outPath | output | 24 | Path word to forward, count decremented |
| evtValid | output | 1 | Path event valid |
| evtCode | output | 2 | Event type: 01 down, 10 nonexistent, 11 unterminated |
| evtPort | output | 3 | Port to return the event through (ingress port) |

## Verification
The bench builds the router with its default parameters: six ports, seven turns and 3-bit fields. With these values the 3-bit turn can encode 6 and 7, which point past the last port, so the nonexistent-port path is reachable. So are wrap-around cases such as ingress 5 with turn 3. A count of 7 reaches the topmost turn field, and ports whose link is down or whose neighbour is not an end node let every event priority be provoked on purpose.

// File: rtl/spath_pkg.sv
package spath_pkg;

  localparam logic [1:0] EVT_DOWN   = 2'b01;
  localparam logic [1:0] EVT_NOPORT = 2'b10;
  localparam logic [1:0] EVT_UNTERM = 2'b11;

  typedef struct packed {
    logic       fwdEn;
    logic       evtEn;
    logic [1:0] evtCode;
  } ctrlStrobe_t;

endpackage

// File: rtl/spath_ctrl.sv
module spath_ctrl
  import spath_pkg::*;
(
  input  logic        inValid,
  input  logic        cntZero,
  input  logic        turnBad,
  input  logic        egressUp,
  input  logic        lastHop,
  input  logic        egressEnd,
  output ctrlStrobe_t strobe
);

  // Priority of failures: unterminated on arrival, bad port, down port, bad last hop (R7)
  always_comb begin
    strobe = '0;
    if (inValid) begin
      if (cntZero) begin
        strobe.evtEn   = 1'b1;
        strobe.evtCode = EVT_UNTERM;
      end else if (turnBad) begin
        strobe.evtEn   = 1'b1;
        strobe.evtCode = EVT_NOPORT;
      end else if (!egressUp) begin
        strobe.evtEn   = 1'b1;
        strobe.evtCode = EVT_DOWN;
      end else if (lastHop && !egressEnd) begin
        strobe.evtEn   = 1'b1;
        strobe.evtCode = EVT_UNTERM;
      end else begin
        strobe.fwdEn = 1'b1;
      end
    end
  end

endmodule

// File: rtl/spath_dp.sv
module spath_dp
  import spath_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int TURN_W    = 3,
  parameter int NUM_TURNS = 7,
  parameter int CNT_W     = 3,
  parameter int PORT_W    = 3,
  parameter int PATH_W    = CNT_W + NUM_TURNS * TURN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PATH_W-1:0] inPath,
  input  logic [PORT_W-1:0] inPort,
  input  logic [NUM_PORTS-1:0] portUp,
  input  logic [NUM_PORTS-1:0] edgeMask,
  input  ctrlStrobe_t       strobe,
  output logic              cntZero,
  output logic              turnBad,
  output logic              egressUp,
  output logic              lastHop,
  output logic              egressEnd,
  output logic              outValid,
  output logic [PORT_W-1:0] outPort,
  output logic [PATH_W-1:0] outPath,
  output logic              evtValid,
  output logic [1:0]        evtCode,
  output logic [PORT_W-1:0] evtPort
);

  localparam int TBL_N  = 2 ** CNT_W;
  localparam int LOW_W  = NUM_TURNS * TURN_W;
  localparam int SUM_W  = ((PORT_W > TURN_W) ? PORT_W : TURN_W) + 1;

  logic [CNT_W-1:0]  curCount;
  logic [TURN_W-1:0] curTurn;
  logic [TURN_W-1:0] turnTbl [TBL_N];
  logic [SUM_W-1:0]  portSum;
  logic [SUM_W-1:0]  portWrap;
  logic [PORT_W-1:0] egress;
  logic              egressOk;
  logic [PATH_W-1:0] nextPath;

  assign curCount = inPath[PATH_W-1 -: CNT_W];

  // Turn lookup: index 0 and indices beyond the turn list read as turn 0 (nonexistent)
  generate
    for (genvar i = 0; i < TBL_N; i++) begin : g_turn
      if (i >= 1 && i <= NUM_TURNS) begin : g_live
        assign turnTbl[i] = inPath[i*TURN_W-1 -: TURN_W];
      end else begin : g_none
        assign turnTbl[i] = '0;
      end
    end
  endgenerate

  assign curTurn  = turnTbl[curCount];
  assign portSum  = SUM_W'(inPort) + SUM_W'(curTurn);
  assign portWrap = (portSum >= SUM_W'(NUM_PORTS)) ? (portSum - SUM_W'(NUM_PORTS)) : portSum;
  assign egress   = portWrap[PORT_W-1:0];
  assign egressOk = (portWrap < SUM_W'(NUM_PORTS));

  assign cntZero   = (curCount == '0);
  assign lastHop   = (curCount == CNT_W'(1));
  assign turnBad   = (curTurn == '0) || (SUM_W'(curTurn) >= SUM_W'(NUM_PORTS)) ||
                     (SUM_W'(inPort) >= SUM_W'(NUM_PORTS));
  assign egressUp  = egressOk && portUp[egress];
  assign egressEnd = egressOk && edgeMask[egress];
  assign nextPath  = {curCount - CNT_W'(1), inPath[LOW_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outPort  <= '0;
      outPath  <= '0;
      evtValid <= 1'b0;
      evtCode  <= '0;
      evtPort  <= '0;
    end else begin
      outValid <= strobe.fwdEn;
      evtValid <= strobe.evtEn;
      if (strobe.fwdEn) begin
        outPort <= egress;
        outPath <= nextPath;
      end
      if (strobe.evtEn) begin
        evtCode <= strobe.evtCode;
        evtPort <= inPort;
      end
    end
  end

  // R2: forwarded egress always names a real port
  p_port_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (SUM_W'(outPort) < SUM_W'(NUM_PORTS)));

  // R2: the count field drops by one across the hop
  p_count_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outPath[PATH_W-1 -: CNT_W] == $past(inPath[PATH_W-1 -: CNT_W]) - CNT_W'(1)));

  // R1: the turn fields travel unchanged
  p_turns_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outPath[LOW_W-1:0] == $past(inPath[LOW_W-1:0])));

endmodule

// File: rtl/spath_router.sv
module spath_router
  import spath_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int TURN_W    = 3,
  parameter int NUM_TURNS = 7,
  parameter int CNT_W     = 3,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int PATH_W   = CNT_W + NUM_TURNS * TURN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic [PATH_W-1:0]    inPath,
  input  logic [PORT_W-1:0]    inPort,
  input  logic [NUM_PORTS-1:0] portUp,
  input  logic [NUM_PORTS-1:0] edgeMask,
  output logic                 outValid,
  output logic [PORT_W-1:0]    outPort,
  output logic [PATH_W-1:0]    outPath,
  output logic                 evtValid,
  output logic [1:0]           evtCode,
  output logic [PORT_W-1:0]    evtPort
);

  ctrlStrobe_t strobe;
  logic cntZero, turnBad, egressUp, lastHop, egressEnd;

  spath_dp #(
    .NUM_PORTS(NUM_PORTS), .TURN_W(TURN_W), .NUM_TURNS(NUM_TURNS),
    .CNT_W(CNT_W), .PORT_W(PORT_W), .PATH_W(PATH_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .inPath(inPath), .inPort(inPort),
    .portUp(portUp), .edgeMask(edgeMask), .strobe(strobe),
    .cntZero(cntZero), .turnBad(turnBad), .egressUp(egressUp),
    .lastHop(lastHop), .egressEnd(egressEnd),
    .outValid(outValid), .outPort(outPort), .outPath(outPath),
    .evtValid(evtValid), .evtCode(evtCode), .evtPort(evtPort)
  );

  spath_ctrl u_ctrl (
    .inValid(inValid), .cntZero(cntZero), .turnBad(turnBad),
    .egressUp(egressUp), .lastHop(lastHop), .egressEnd(egressEnd),
    .strobe(strobe)
  );

  // R9: never both result kinds at once
  p_one_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(outValid && evtValid));

  // R9: each request gets a result next cycle
  p_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (outValid || evtValid));

  // R9: no result without a request
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !(outValid || evtValid));

  // R3: zero count on arrival reports unterminated
  p_zero_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inPath[PATH_W-1 -: CNT_W] == '0) |=> (evtValid && evtCode == EVT_UNTERM));

  // R8: events return through the ingress port
  p_evt_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |-> (evtPort == $past(inPort)));

  // R2: a forward never leaves through the ingress port
  p_no_self_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outPort != $past(inPort)));

endmodule

// File: tb/tb_spath_router.sv
`timescale 1ns/1ps
module tb_spath_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inPath = '0;
  logic [2:0]  inPort = '0;
  logic [5:0]  portUp = '0;
  logic [5:0]  edgeMask = '0;
  logic        outValid, evtValid;
  logic [2:0]  outPort, evtPort;
  logic [23:0] outPath;
  logic [1:0]  evtCode;

  always #4 clk = ~clk;

  spath_router dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inPath(inPath),
    .inPort(inPort), .portUp(portUp), .edgeMask(edgeMask),
    .outValid(outValid), .outPort(outPort), .outPath(outPath),
    .evtValid(evtValid), .evtCode(evtCode), .evtPort(evtPort)
  );

  typedef struct packed {
    logic        isEvt;
    logic [2:0]  port;
    logic [23:0] path;
    logic [1:0]  code;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic model(input [23:0] p, input [2:0] ip, input [5:0] up, input [5:0] em,
                       output exp_t e, output string tag);
    int cnt, t, eg;
    cnt = p[23:21];
    e = '0;
    if (cnt == 0) begin
      e.isEvt = 1; e.code = 2'b11; e.port = ip; tag = "R3 R8";
    end else begin
      t = (p >> (3*(cnt-1))) & 7;
      if (ip >= 6 || t == 0 || t >= 6) begin
        e.isEvt = 1; e.code = 2'b10; e.port = ip; tag = "R4 R8";
      end else begin
        eg = (ip + t) % 6;
        if (!up[eg]) begin
          e.isEvt = 1; e.code = 2'b01; e.port = ip; tag = "R5 R8";
        end else if (cnt == 1 && !em[eg]) begin
          e.isEvt = 1; e.code = 2'b11; e.port = ip; tag = "R6 R8";
        end else begin
          e.port = 3'(eg);
          e.path = {3'(cnt-1), p[20:0]};
          tag = (cnt == 1) ? "R6 R2 R1" : "R2 R1";
        end
      end
    end
  endtask

  // Driver: called at a falling edge, returns at the next one
  task automatic send(input [23:0] p, input [2:0] ip, input [5:0] up, input [5:0] em, input string note);
    exp_t e; string tag;
    model(p, ip, up, em, e, tag);
    expQ.push_back(e);
    tagQ.push_back({tag, " ", note});
    inValid = 1; inPath = p; inPort = ip; portUp = up; edgeMask = em;
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic idle(input int n);
    inValid = 0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Path with turn fields all 2 except the one selected by the count
  function automatic [23:0] mkPath(input [2:0] cnt, input [2:0] t);
    logic [23:0] p;
    p = {3'(cnt), 21'o2222222};
    if (cnt != 0) p[3*cnt-1 -: 3] = t;
    return p;
  endfunction

  // Monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (outValid || evtValid) begin
          if (expQ.size() == 0) begin
            check(0, "R9 spurious result", {30'd0, outValid, evtValid}, 0);
          end else begin
            exp_t e; string tag;
            e = expQ.pop_front();
            tag = tagQ.pop_front();
            check(!(outValid && evtValid), {tag, " R9 both valid"}, 1, 0);
            if (e.isEvt) begin
              check(evtValid, {tag, " kind"}, {31'd0, evtValid}, 1);
              check(evtCode == e.code, {tag, " code"}, 32'(evtCode), 32'(e.code));
              check(evtPort == e.port, {tag, " evtPort"}, 32'(evtPort), 32'(e.port));
            end else begin
              check(outValid, {tag, " kind"}, {31'd0, outValid}, 1);
              check(outPort == e.port, {tag, " outPort"}, 32'(outPort), 32'(e.port));
              check(outPath == e.path, {tag, " outPath"}, 32'(outPath), 32'(e.path));
            end
          end
        end else if (expQ.size() != 0) begin
          check(0, {tagQ[0], " R9 missing result"}, 0, 1);
          void'(expQ.pop_front());
          void'(tagQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #2;
    // R9: reset state
    check({outValid, evtValid, outPort, outPath, evtCode, evtPort} == '0, "R9 reset outputs",
          32'({outValid, evtValid, evtCode, evtPort}), 0);
    @(negedge clk);

    send(mkPath(3'd3, 3'd2), 3'd1, 6'h3f, 6'h00, "basic forward");
    send(mkPath(3'd2, 3'd3), 3'd5, 6'h3f, 6'h00, "wrap 5+3");
    send(mkPath(3'd0, 3'd0), 3'd2, 6'h3f, 6'h3f, "count zero");
    send(mkPath(3'd4, 3'd0), 3'd0, 6'h3f, 6'h00, "turn 0");
    send(mkPath(3'd4, 3'd6), 3'd0, 6'h3f, 6'h00, "turn 6");
    send(mkPath(3'd4, 3'd7), 3'd3, 6'h3f, 6'h00, "turn 7");
    send(mkPath(3'd2, 3'd1), 3'd6, 6'h3f, 6'h00, "ingress 6");
    send(mkPath(3'd2, 3'd4), 3'd0, 6'h2f, 6'h00, "egress 4 down");
    send(mkPath(3'd1, 3'd2), 3'd3, 6'h3f, 6'h1f, "last hop to switch");
    send(mkPath(3'd1, 3'd2), 3'd3, 6'h3f, 6'h20, "last hop to end node");
    // R1: count 7 selects top field; other fields differ
    send({3'd7, 3'd1, 18'o333333}, 3'd0, 6'h3f, 6'h00, "top field");
    send({3'd1, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd4}, 3'd1, 6'h3f, 6'h20, "bottom field");
    // R7: priority cases
    send(mkPath(3'd0, 3'd0), 3'd0, 6'h00, 6'h00, "R7 zero over down");
    send(mkPath(3'd1, 3'd7), 3'd0, 6'h00, 6'h00, "R7 badport over down");
    send(mkPath(3'd1, 3'd1), 3'd0, 6'h00, 6'h00, "R7 down over last hop");
    idle(5);

    for (int i = 0; i < 400; i++) begin
      logic [23:0] p; logic [2:0] ip; logic [5:0] up, em;
      p  = 24'($urandom);
      ip = 3'($urandom_range(0, 6));
      up = 6'($urandom) | 6'($urandom);
      em = 6'($urandom);
      send(p, ip, up, em, "random");
      if (i % 37 == 0) idle(2);
    end
    idle(4);
    check(expQ.size() == 0, "R9 queue drained", 32'(expQ.size()), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule